// File: doc/BRIEF.md
# HDLC Transmit Framer

The framer turns byte-wide packets into a serial HDLC bit stream, producing exactly one line bit on every clock cycle in which the bit enable is high. Packet bytes come in over a valid/ready handshake that carries start-of-packet and end-of-packet markers. In framed mode the block surrounds each packet with flag bytes, may append a 16-bit or 32-bit checksum, and inserts a zero after any run of five ones. Between packets it fills the line with either flag bytes or all-ones bytes.

A set of configuration inputs controls the options. Transparent mode passes the data bits through with no flags, checksum or bit insertion. The other options select bit order within each byte, invert the whole line, and deliberately corrupt the checksum to exercise a receiver's error path. Configuration inputs are sampled only at the start of each idle fill byte, so a packet keeps the settings it started with.

A packet that runs out of data mid-way is terminated with eight ones. A separate forced-abort input overrides everything. While it is held, the line is all ones and any packet in progress is dropped.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is asserted, `tx_bit` is 1. After reset the engine starts at the first bit of an idle fill byte.
- R2: Between packets the line carries fill bytes, sent bit 0 first: 0,1,1,1,1,1,1,0 (7Eh) when `cfg_fill_ones` is 0, and eight ones (FFh) when it is 1.
- R3: A framed packet starts only at a fill-byte boundary with `in_valid` and `in_sop` high. It is sent as an opening 7Eh flag, then the data bits, then the FCS if one is selected, then a closing 7Eh flag. Each byte is taken on a cycle with `in_valid` and `in_ready` both high, and `in_eop` marks the last byte.
- R4: In framed mode a 0 is inserted after every five consecutive ones within the data and FCS bits, including a run that ends the FCS or the data. Flags, fill and abort bits are never stuffed.
- R5: `cfg_fcs_sel` 01 selects a 16-bit CRC (polynomial x^16+x^12+x^5+1, preset FFFFh). Code 10 selects the 32-bit CRC (polynomial 04C11DB7h in reflected form, preset FFFFFFFFh). Codes 00 and 11 mean no FCS. The CRC covers the data bits in line order, and its complemented remainder is sent least significant bit first.
- R6: With `cfg_bad_fcs` set, every FCS bit on the line is the inverse of the correct FCS bit.
- R7: With `cfg_msb_first` 0 the bits of each byte go out from bit 0 to bit 7. With it set they go from bit 7 to bit 0, and the CRC is taken over the bits in that sent order.
- R8: With `cfg_invert` set, every bit the framer emits is complemented on `tx_bit`: fill, flags, data, stuffed zeros, FCS and underflow abort.
- R9: With `cfg_raw` set, a packet's bytes go out back to back with no flags, no FCS (whatever `cfg_fcs_sel` holds) and no inserted zeros. The first byte is taken at the fill-byte boundary, and fill resumes right after the last bit.
- R10: When the engine needs the next byte of a packet and `in_valid` is low, it sends eight ones instead of the remaining data, FCS and closing flag, and then returns to fill.
- R11: On any enabled cycle with `cfg_force_abort` high, `tx_bit` becomes 1 (not inverted), no byte is accepted, any packet in progress is dropped, and fill resumes at a byte boundary once the input falls. This holds in transparent mode too.
- R12: Configuration inputs take effect only at fill-byte boundaries. A change during a packet or in the middle of a fill byte has no effect until the next fill-byte boundary. `cfg_force_abort` is the exception.
- R13: `tx_bit` changes, and bytes are accepted, only on cycles with `bit_en` high. `tx_bit` is registered one clock after the bit is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Advance the line by one bit this cycle |
| cfg_raw | input | 1 | Transparent mode |
| cfg_fill_ones | input | 1 | Fill byte FFh instead of 7Eh |
| cfg_fcs_sel | input | 2 | FCS choice: 00 none, 01 16-bit, 10 32-bit, 11 none |
| cfg_invert | input | 1 | Complement the whole line |
| cfg_msb_first | input | 1 | Send bit 7 of each byte first |
| cfg_bad_fcs | input | 1 | Invert all FCS bits |
| cfg_force_abort | input | 1 | Hold the line at all ones and drop the packet |
| in_valid | input | 1 | Byte on `in_data` is available |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_ready | output | 1 | Byte is taken this cycle if valid |
| tx_bit | output | 1 | Serial line output |

## Verification
Most internal faults show up on `tx_bit` within a bit or two. A wrong ones counter misplaces an inserted zero and shifts every later bit. A wrong bit counter breaks a flag, and a bad CRC register corrupts the FCS bits that follow. Because all later bits move, a reference that predicts every line bit and compares it on every clock catches these faults within a byte. A handshake fault, such as taking a byte early or in the wrong slot, repeats or skips eight data bits at once. Faults in configuration latching only show when settings change in the middle of a packet or a fill byte, so the stimulus changes them at exactly those points.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter logic [7:0] FLAG = 8'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       cfg_raw,
  input  logic       cfg_fill_ones,
  input  logic [1:0] cfg_fcs_sel,
  input  logic       cfg_invert,
  input  logic       cfg_msb_first,
  input  logic       cfg_bad_fcs,
  input  logic       cfg_force_abort,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       in_ready,
  output logic       tx_bit
);

  typedef enum logic [2:0] {S_FILL, S_OPEN, S_DATA, S_FCS, S_CLOSE, S_ABRT} st_t;

  st_t         st;
  logic [4:0]  cnt;
  logic [2:0]  ones;
  logic [7:0]  sh;
  logic [31:0] crc;
  logic        last;
  logic [6:0]  act;

  logic [6:0] cfg_now, cur;
  logic       at_bound, raw, fill1, inv, msb, bad, is32, fcs_on;
  logic [1:0] sel;
  logic [4:0] fcs_last;
  logic       start, stuff, need;
  logic [7:0] ord;
  logic       b;
  logic [31:0] poly, crc_nx;
  logic [2:0] ones_nx;

  assign cfg_now  = {cfg_bad_fcs, cfg_msb_first, cfg_invert, cfg_fcs_sel, cfg_fill_ones, cfg_raw};
  assign at_bound = (st == S_FILL) && (cnt == 5'd0);
  assign cur      = at_bound ? cfg_now : act;
  assign raw      = cur[0];
  assign fill1    = cur[1];
  assign sel      = cur[3:2];
  assign inv      = cur[4];
  assign msb      = cur[5];
  assign bad      = cur[6];
  assign is32     = (sel == 2'b10);
  assign fcs_on   = !raw && (sel[0] ^ sel[1]);
  assign fcs_last = is32 ? 5'd31 : 5'd15;

  assign start = bit_en && !cfg_force_abort && at_bound && in_valid && in_sop;
  assign stuff = !raw && (ones == 3'd5) &&
                 ((st == S_DATA) || (st == S_FCS) || ((st == S_CLOSE) && (cnt == 5'd0)));
  assign need  = (st == S_DATA) && (cnt == 5'd0) && !stuff;
  assign in_ready = bit_en && !cfg_force_abort &&
                    (need || (at_bound && raw && in_valid && in_sop));

  always_comb
    for (int i = 0; i < 8; i++) ord[i] = msb ? in_data[7-i] : in_data[i];

  always_comb begin
    b = 1'b1;
    case (st)
      S_FILL:  b = start ? (raw ? ord[0] : FLAG[0]) : (fill1 ? 1'b1 : FLAG[cnt[2:0]]);
      S_OPEN:  b = FLAG[cnt[2:0]];
      S_DATA:  b = stuff ? 1'b0 : (cnt == 5'd0) ? (in_valid ? ord[0] : 1'b1) : sh[0];
      S_FCS:   b = stuff ? 1'b0 : (~crc[0] ^ bad);
      S_CLOSE: b = stuff ? 1'b0 : FLAG[cnt[2:0]];
      default: b = 1'b1;
    endcase
  end

  assign poly    = is32 ? 32'hEDB8_8320 : 32'h0000_8408;
  assign crc_nx  = {1'b0, crc[31:1]} ^ ((crc[0] ^ b) ? poly : 32'h0);
  assign ones_nx = b ? ones + 3'd1 : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FILL; cnt <= '0; ones <= '0; sh <= '0; crc <= '0;
      last <= 1'b0; act <= '0; tx_bit <= 1'b1;
    end else if (bit_en) begin
      tx_bit <= cfg_force_abort ? 1'b1 : (b ^ inv);
      act    <= cur;
      if (cfg_force_abort) begin
        st <= S_FILL; cnt <= '0; ones <= '0;
      end else begin
        case (st)
          S_FILL:
            if (start) begin
              ones <= '0;
              crc  <= is32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
              cnt  <= 5'd1;
              if (raw) begin
                st <= S_DATA; sh <= {1'b0, ord[7:1]}; last <= in_eop;
              end else st <= S_OPEN;
            end else cnt <= (cnt == 5'd7) ? 5'd0 : cnt + 5'd1;
          S_OPEN:
            if (cnt == 5'd7) begin st <= S_DATA; cnt <= '0; end
            else cnt <= cnt + 5'd1;
          S_DATA:
            if (stuff) ones <= '0;
            else if ((cnt == 5'd0) && !in_valid) begin st <= S_ABRT; cnt <= 5'd1; end
            else begin
              ones <= raw ? 3'd0 : ones_nx;
              crc  <= crc_nx;
              if (cnt == 5'd0) begin sh <= {1'b0, ord[7:1]}; last <= in_eop; end
              else sh <= {1'b0, sh[7:1]};
              if (cnt == 5'd7) begin
                cnt <= '0;
                if (last) st <= raw ? S_FILL : (fcs_on ? S_FCS : S_CLOSE);
              end else cnt <= cnt + 5'd1;
            end
          S_FCS:
            if (stuff) ones <= '0;
            else begin
              ones <= ones_nx;
              crc  <= {1'b0, crc[31:1]};
              if (cnt == fcs_last) begin st <= S_CLOSE; cnt <= '0; end
              else cnt <= cnt + 5'd1;
            end
          S_CLOSE:
            if (stuff) ones <= '0;
            else if (cnt == 5'd7) begin st <= S_FILL; cnt <= '0; end
            else cnt <= cnt + 5'd1;
          S_ABRT:
            if (cnt == 5'd7) begin st <= S_FILL; cnt <= '0; end
            else cnt <= cnt + 5'd1;
          default: begin st <= S_FILL; cnt <= '0; end
        endcase
      end
    end
  end

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  assert_force_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && cfg_force_abort) |=> tx_bit);

  assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !cfg_force_abort && stuff) |=> (tx_bit == act[4]));

  assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd5);

  assert_abort_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABRT) |-> (tx_bit == !act[4]));

  assert_fcs_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FCS) |-> (!act[0] && (act[3] != act[2])));

  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !at_bound |=> $stable(act));

endmodule

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, bit_en = 1'b0;
  logic       cfg_raw = 0, cfg_fill_ones = 0, cfg_invert = 0, cfg_msb_first = 0;
  logic       cfg_bad_fcs = 0, cfg_force_abort = 0;
  logic [1:0] cfg_fcs_sel = 2'b00;
  logic       in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, tx_bit;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_raw(cfg_raw),
    .cfg_fill_ones(cfg_fill_ones), .cfg_fcs_sel(cfg_fcs_sel), .cfg_invert(cfg_invert),
    .cfg_msb_first(cfg_msb_first), .cfg_bad_fcs(cfg_bad_fcs),
    .cfg_force_abort(cfg_force_abort), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready), .tx_bit(tx_bit));

  localparam logic [7:0] FLAGV = 8'h7E;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  bit   exp_q[$];
  int   fill_idx = 0;
  logic exp_pin = 1'b1;
  logic m_inv = 0, m_fill1 = 0, m_raw = 0, m_msb = 0, m_bad = 0;
  logic [1:0] m_sel = 0;

  logic [7:0] frm[$];
  int ptr = 0, avail = 0;
  bit active = 0, pending = 0, took = 0, rand_en = 0;

  task automatic chk(input logic a, input logic e, input string what);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, a, e);
    end
  endtask

  task automatic chk32(input logic [31:0] a, input logic [31:0] e, input string what);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  function automatic logic [31:0] fcs_of(input bit d[$], input bit wide);
    logic [31:0] c, p;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    p = wide ? 32'hEDB8_8320 : 32'h0000_8408;
    foreach (d[i]) begin
      bit fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ p;
    end
    return wide ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic build();
    bit data[$];
    bit body[$];
    int k, run;
    logic [31:0] f;
    k = (avail < frm.size()) ? avail : frm.size();
    for (int j = 0; j < k; j++)
      for (int i = 0; i < 8; i++) data.push_back(m_msb ? frm[j][7-i] : frm[j][i]);
    if (m_raw) begin
      foreach (data[i]) exp_q.push_back(data[i]);
      if (k < frm.size()) for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
      return;
    end
    for (int i = 0; i < 8; i++) exp_q.push_back(FLAGV[i]);
    body = data;
    if (k == frm.size() && (m_sel == 2'b01 || m_sel == 2'b10)) begin
      f = fcs_of(data, m_sel == 2'b10);
      if (m_bad) f = ~f;
      for (int i = 0; i < ((m_sel == 2'b10) ? 32 : 16); i++) body.push_back(f[i]);
    end
    run = 0;
    foreach (body[i]) begin
      exp_q.push_back(body[i]);
      run = body[i] ? run + 1 : 0;
      if (run == 5) begin exp_q.push_back(1'b0); run = 0; end
    end
    if (k < frm.size()) for (int i = 0; i < 8; i++) exp_q.push_back(1'b1);
    else for (int i = 0; i < 8; i++) exp_q.push_back(FLAGV[i]);
  endtask

  task automatic model();
    if (!bit_en) return;
    if (cfg_force_abort) begin
      exp_pin = 1'b1; exp_q.delete(); fill_idx = 0;
      return;
    end
    if (exp_q.size() == 0) begin
      if (fill_idx == 0) begin
        m_raw = cfg_raw; m_fill1 = cfg_fill_ones; m_sel = cfg_fcs_sel;
        m_inv = cfg_invert; m_msb = cfg_msb_first; m_bad = cfg_bad_fcs;
      end
      if (fill_idx == 0 && pending) begin
        build(); pending = 0;
      end else begin
        exp_q.push_back(m_fill1 ? 1'b1 : FLAGV[fill_idx]);
        fill_idx = (fill_idx + 1) % 8;
      end
    end
    exp_pin = exp_q.pop_front() ^ m_inv;
  endtask

  task automatic step();
    bit_en   = rand_en ? ($urandom_range(0, 3) != 0) : 1'b1;
    in_valid = active && (ptr < avail) && (ptr < frm.size());
    in_data  = (ptr < frm.size()) ? frm[ptr] : 8'h00;
    in_sop   = (ptr == 0);
    in_eop   = (ptr == frm.size() - 1);
    if (rst_n) model();
    #1 took = in_valid && in_ready;
    if (in_ready && !bit_en) chk(in_ready, 1'b0, "ready without bit enable");
    @(negedge clk);
    chk(tx_bit, exp_pin, "line bit");
    if (took) begin
      ptr++;
      if (ptr >= frm.size()) active = 0;
    end
  endtask

  task automatic send(input int av);
    avail = (av < 0) ? frm.size() : av;
    ptr = 0; active = 1; pending = 1;
    do step(); while (pending || exp_q.size() != 0);
    active = 0;
    repeat (3) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL %s watchdog: actual=running expected=finished", tag);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit kb[$];
    logic [7:0] s[$];
    tag = "R1";
    repeat (3) step();
    rst_n = 1'b1;
    tag = "R2"; repeat (24) step();
    tag = "R12"; cfg_fill_ones = 1; repeat (12) step();
    tag = "R2"; repeat (16) step();
    cfg_fill_ones = 0; repeat (16) step();

    tag = "R3"; cfg_fcs_sel = 2'b01; frm = '{8'h01, 8'h80, 8'hA5}; send(-1);
    frm = '{8'h42}; send(-1);
    tag = "R4"; frm = '{8'hFF, 8'hFF, 8'hFF, 8'h7E, 8'hF8, 8'h1F}; send(-1);
    cfg_fcs_sel = 2'b00; frm = '{8'h1F}; send(-1);
    tag = "R5"; cfg_fcs_sel = 2'b10; frm = '{8'h12, 8'h34, 8'h56, 8'h78, 8'hFF}; send(-1);
    cfg_fcs_sel = 2'b00; frm = '{8'hC3, 8'h3C}; send(-1);
    cfg_fcs_sel = 2'b11; frm = '{8'hC3, 8'h3C}; send(-1);
    s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    foreach (s[j]) for (int i = 0; i < 8; i++) kb.push_back(s[j][i]);
    chk32(fcs_of(kb, 0), 32'h0000_906E, "16-bit check value");
    chk32(fcs_of(kb, 1), 32'hCBF4_3926, "32-bit check value");
    tag = "R6"; cfg_bad_fcs = 1; cfg_fcs_sel = 2'b01; frm = '{8'hAA, 8'h55}; send(-1);
    cfg_fcs_sel = 2'b10; send(-1);
    cfg_bad_fcs = 0;
    tag = "R7"; cfg_msb_first = 1; cfg_fcs_sel = 2'b01; frm = '{8'h80, 8'h01, 8'hF0}; send(-1);
    cfg_msb_first = 0;
    tag = "R8"; cfg_invert = 1; repeat (20) step();
    frm = '{8'hFF, 8'hFE, 8'h00}; send(-1);
    cfg_fill_ones = 1; repeat (20) step();
    cfg_fill_ones = 0; cfg_invert = 0; repeat (10) step();

    tag = "R12"; frm = '{8'h11, 8'h22, 8'h33, 8'h44};
    avail = frm.size(); ptr = 0; active = 1; pending = 1;
    repeat (15) step();
    cfg_invert = 1; cfg_msb_first = 1; cfg_fcs_sel = 2'b10;
    do step(); while (pending || exp_q.size() != 0);
    active = 0; repeat (12) step();
    cfg_invert = 0; cfg_msb_first = 0; cfg_fcs_sel = 2'b01; repeat (10) step();

    tag = "R9"; cfg_raw = 1; frm = '{8'hFF, 8'hFF, 8'hFF, 8'h00}; send(-1);
    cfg_msb_first = 1; frm = '{8'h01, 8'h7E}; send(-1);
    cfg_msb_first = 0;
    tag = "R10"; frm = '{8'hA1, 8'hB2, 8'hC3}; send(1);
    cfg_raw = 0; frm = '{8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h99}; send(2);
    frm = '{8'hFF, 8'hFF, 8'h3F}; send(2);

    tag = "R11"; cfg_force_abort = 1; repeat (10) step();
    cfg_force_abort = 0; repeat (12) step();
    cfg_raw = 1; cfg_invert = 1; cfg_force_abort = 1; repeat (6) step();
    cfg_force_abort = 0; repeat (10) step();
    cfg_raw = 0; cfg_invert = 0;
    frm = '{8'h12, 8'h34, 8'h56}; avail = frm.size(); ptr = 0; active = 1; pending = 1;
    repeat (20) step();
    cfg_force_abort = 1; step(); active = 0; step();
    cfg_force_abort = 0; repeat (20) step();

    tag = "R13"; rand_en = 1;
    frm = '{8'hFF, 8'h81, 8'h7E}; send(-1);
    cfg_fcs_sel = 2'b10; frm = '{8'hDE, 8'hAD}; send(-1);
    cfg_raw = 1; frm = '{8'h5A, 8'hA5}; send(-1);
    cfg_raw = 0; frm = '{8'hFF, 8'hFF, 8'hFF}; send(1);
    repeat (20) step();
    rand_en = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule